// File: doc/BRIEF.md
# SPI Master Serial Clock and Chip-Select Timer

This block derives the serial clock and the active-low chip select of an SPI master from a faster system clock. A one-cycle start request carries the number of bits in the frame. The block then lowers chip select, waits a programmable setup time, and produces two SCLK edges per bit. It returns SCLK to its idle level, raises chip select, and waits a programmable inactive time. When that time has elapsed it reports completion with a one-cycle done pulse.

Two one-cycle strobes go alongside SCLK. The neighbouring shift logic uses them to place the next bit on the line (launch) and to capture the incoming bit (sample). All settings are captured when a transfer is accepted: the clock ratio, the idle polarity, the phase, the setup count and the inactive count. A transfer is refused, and an error pulse is raised, when the ratio is not one that the clock tree allows or when the bit count is zero.

Top module: `spi_sclk_timer`

## Requirements
- R1: A start is accepted only when the ratio is 1, or is even and lies in 2..MAX_RATIO (510 by default). For any other ratio (0, any odd value above 1, or anything above 510), `err_o` is high for exactly the one cycle after the start, `cs_n_o` stays 1, and no done pulse follows.
- R2: Each SCLK half period lasts H system cycles, where H = ratio/2. A ratio of 1 asks for a rate at or above the source clock and gets the fastest rate the registered outputs can make, which is H = 1.
- R3: With setup count N, the first SCLK edge appears (N+1)·H cycles after `cs_n_o` falls.
- R4: A frame of B bits has exactly 2·B SCLK edges spaced H cycles apart. SCLK rests at the CPOL level (0 = idles low, 1 = idles high) outside the edges and is back at that level before `cs_n_o` rises. `cs_n_o` rises H cycles after the last edge.
- R5: With inactive count M, `done_o` is a single-cycle pulse that comes (M+1)·H cycles after `cs_n_o` rises. In that same cycle the block can accept a new start.
- R6: With CPHA = 0, `sample_o` marks each odd-numbered edge (1, 3, …). `launch_o` marks the cycle in which chip select falls and each even-numbered edge except the last.
- R7: With CPHA = 1, `launch_o` marks each odd-numbered edge and `sample_o` marks each even-numbered edge.
- R8: `launch_o` and `sample_o` are never high in the same cycle. Each transfer gives B launches and B samples.
- R9: All settings are captured at the accepted start. Changing them during a transfer has no effect on the waveform, and a start pulse while busy is ignored.
- R10: A start with a bit count of zero is refused in the same way as in R1.
- R11: After reset `cs_n_o` = 1 and `sclk_o`, `launch_o`, `sample_o`, `done_o` and `err_o` are all 0. While idle, `sclk_o` follows the CPOL input with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, one cycle |
| bit_count_i | input | CNT_W | Bits in the frame (B) |
| ratio_i | input | DIV_W | System clock to SCLK ratio |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cs_setup_i | input | TW | Setup count N, in half periods minus one |
| cs_hold_i | input | TW | Inactive count M, in half periods minus one |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| launch_o | output | 1 | Drive-next-bit strobe |
| sample_o | output | 1 | Capture-bit strobe |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Refused-start pulse |

## Verification
Every output is registered. The edge at which a start is sampled therefore sets `cs_n_o` low, fires the CPHA-0 launch, or raises `err_o`, and the result shows in the next cycle. Calling that cycle t = 0, edge k is due at t = (N+k)·H, chip select rises at (N+2B+1)·H, and done is due at (N+2B+M+2)·H. The bench computes these times from the settings alone. It samples every output at the falling clock edge for each t up to done plus one and compares the whole waveform cycle by cycle. It also scrambles the settings and pulses start in the middle of each transfer.

// File: rtl/spi_tmr_pkg.sv
package spi_tmr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/spi_tmr_ratio_chk.sv
module spi_tmr_ratio_chk #(
  parameter int DIV_W     = 10,
  parameter int MAX_RATIO = 510,
  localparam int HW       = DIV_W - 1
) (
  input  logic [DIV_W-1:0] ratio_i,
  output logic             ok_o,
  output logic [HW-1:0]    half_o
);
  logic is_bypass;
  logic in_range;

  assign is_bypass = (ratio_i == DIV_W'(1));

  generate
    if (MAX_RATIO >= (1 << DIV_W) - 1) begin : g_no_cap
      assign in_range = 1'b1;
    end else begin : g_cap
      localparam logic [DIV_W-1:0] CAP = DIV_W'(MAX_RATIO);
      assign in_range = (ratio_i <= CAP);
    end
  endgenerate

  assign ok_o   = is_bypass || (!ratio_i[0] && (ratio_i != '0) && in_range);
  assign half_o = is_bypass ? HW'(1) : ratio_i[DIV_W-1:1];
endmodule

// File: rtl/spi_tmr_halfper.sv
module spi_tmr_halfper #(
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= half_i - HW'(1);
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= half_i - HW'(1);
      else             cnt_q <= cnt_q - HW'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (run_i && !restart_i) |-> (cnt_q < half_i)) else $error("half counter out of range"); // R2
endmodule

// File: rtl/spi_tmr_strobe.sv
module spi_tmr_strobe #(
  parameter int ECW = 7
) (
  input  logic           start_go_i,
  input  logic           cpha_live_i,
  input  logic           cpha_q_i,
  input  logic           edge_fire_i,
  input  logic [ECW-1:0] edge_n_i,
  input  logic [ECW-1:0] edge_tot_i,
  output logic           launch_d_o,
  output logic           sample_d_o
);
  logic [ECW-1:0] idx;
  logic           idx_odd;
  logic           idx_last;

  assign idx      = edge_n_i + ECW'(1);
  assign idx_odd  = idx[0];
  assign idx_last = (idx == edge_tot_i);

  always_comb begin
    launch_d_o = start_go_i && !cpha_live_i;
    sample_d_o = 1'b0;
    if (edge_fire_i) begin
      if (cpha_q_i) begin
        launch_d_o = idx_odd;
        sample_d_o = !idx_odd;
      end else begin
        launch_d_o = !idx_odd && !idx_last;
        sample_d_o = idx_odd;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer
  import spi_tmr_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int MAX_RATIO = 510,
  parameter int CNT_W     = 6,
  parameter int TW        = 8,
  localparam int HW       = DIV_W - 1,
  localparam int ECW      = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] bit_count_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [TW-1:0]    cs_setup_i,
  input  logic [TW-1:0]    cs_hold_i,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             launch_o,
  output logic             sample_o,
  output logic             done_o,
  output logic             err_o
);
  tmr_state_e     state_q;
  logic           cpol_q, cpha_q;
  logic [HW-1:0]  half_q;
  logic [TW-1:0]  hold_q;
  logic [TW-1:0]  halves_q;
  logic [ECW-1:0] edge_n_q;
  logic [ECW-1:0] edge_tot_q;

  logic           cfg_ok;
  logic [HW-1:0]  half_live;
  logic           start_go, start_bad;
  logic           tick, edge_fire;
  logic           launch_d, sample_d;
  logic           is_idle;

  spi_tmr_ratio_chk #(.DIV_W(DIV_W), .MAX_RATIO(MAX_RATIO)) u_chk (
    .ratio_i (ratio_i),
    .ok_o    (cfg_ok),
    .half_o  (half_live)
  );

  assign is_idle   = (state_q == ST_IDLE);
  assign start_go  = is_idle && start_i && cfg_ok && (bit_count_i != '0);
  assign start_bad = is_idle && start_i && !(cfg_ok && (bit_count_i != '0));

  spi_tmr_halfper #(.HW(HW)) u_half (
    .clk       (clk),
    .rst       (rst),
    .restart_i (start_go),
    .run_i     (!is_idle),
    .half_i    (start_go ? half_live : half_q),
    .tick_o    (tick)
  );

  assign edge_fire = tick &&
    (((state_q == ST_SETUP) && (halves_q == '0)) ||
     ((state_q == ST_SHIFT) && (edge_n_q != edge_tot_q)));

  spi_tmr_strobe #(.ECW(ECW)) u_strobe (
    .start_go_i  (start_go),
    .cpha_live_i (cpha_i),
    .cpha_q_i    (cpha_q),
    .edge_fire_i (edge_fire),
    .edge_n_i    (edge_n_q),
    .edge_tot_i  (edge_tot_q),
    .launch_d_o  (launch_d),
    .sample_d_o  (sample_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      half_q     <= HW'(1);
      hold_q     <= '0;
      halves_q   <= '0;
      edge_n_q   <= '0;
      edge_tot_q <= '0;
      sclk_o     <= 1'b0;
      cs_n_o     <= 1'b1;
      launch_o   <= 1'b0;
      sample_o   <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      launch_o <= launch_d;
      sample_o <= sample_d;
      done_o   <= 1'b0;
      err_o    <= start_bad;
      if (edge_fire) begin
        sclk_o   <= ~sclk_o;
        edge_n_q <= edge_n_q + ECW'(1);
      end
      unique case (state_q)
        ST_IDLE: begin
          sclk_o <= cpol_i;
          if (start_go) begin
            cpol_q     <= cpol_i;
            cpha_q     <= cpha_i;
            half_q     <= half_live;
            hold_q     <= cs_hold_i;
            halves_q   <= cs_setup_i;
            edge_n_q   <= '0;
            edge_tot_q <= {bit_count_i, 1'b0};
            cs_n_o     <= 1'b0;
            state_q    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            if (halves_q == '0) state_q  <= ST_SHIFT;
            else                halves_q <= halves_q - TW'(1);
          end
        end
        ST_SHIFT: begin
          if (tick && (edge_n_q == edge_tot_q)) begin
            cs_n_o   <= 1'b1;
            halves_q <= hold_q;
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (halves_q == '0) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              halves_q <= halves_q - TW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(launch_o && sample_o)) else $error("launch and sample together"); // R8
  AST_IDLE_BEFORE_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (sclk_o == cpol_q)) else $error("sclk not idle at cs rise"); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R5
  AST_ERR_KEEPS_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    err_o |-> cs_n_o) else $error("cs active after refused start"); // R1
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> !cs_n_o) else $error("sample outside frame"); // R6
  AST_SCLK_MOVES_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sclk_o) && !is_idle) |-> !cs_n_o) else $error("sclk edge with cs high"); // R4
endmodule

// File: tb/spi_sclk_timer_test.sv
module spi_sclk_timer_test;
  localparam int DIV_W = 10;
  localparam int CNT_W = 6;
  localparam int TW    = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] bits_i = '0;
  logic [DIV_W-1:0] ratio_i = DIV_W'(2);
  logic             cpol_i = 1'b0;
  logic             cpha_i = 1'b0;
  logic [TW-1:0]    setup_i = '0;
  logic [TW-1:0]    hold_i = '0;
  logic sclk_o, cs_n_o, launch_o, sample_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_sclk_timer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_count_i(bits_i),
    .ratio_i(ratio_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .cs_setup_i(setup_i), .cs_hold_i(hold_i),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .launch_o(launch_o),
    .sample_o(sample_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_xfer(input int ratio, input bit pol, input bit pha,
                          input int b, input int n, input int m);
    int h, td, q, r, k, ke;
    int m_cs, m_sc, m_ln, m_sp, m_dn, m_er, both;
    bit edge_now, cs_e, sc_e, ln_e, sp_e;
    h  = (ratio == 1) ? 1 : ratio / 2;
    td = (n + 2*b + m + 2) * h;
    m_cs = 0; m_sc = 0; m_ln = 0; m_sp = 0; m_dn = 0; m_er = 0; both = 0;
    ratio_i = DIV_W'(ratio); cpol_i = pol; cpha_i = pha;
    bits_i = CNT_W'(b); setup_i = TW'(n); hold_i = TW'(m); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= td + 1; t++) begin
      q = t / h; r = t % h;
      if (q < n + 1) k = 0;
      else k = (q - n > 2*b) ? 2*b : q - n;
      ke = q - n;
      edge_now = (r == 0) && (q >= n + 1) && (ke <= 2*b);
      cs_e = !(t < (n + 2*b + 1) * h);
      sc_e = pol ^ k[0];
      if (pha) begin
        ln_e = edge_now && ke[0];
        sp_e = edge_now && !ke[0];
      end else begin
        ln_e = (t == 0) || (edge_now && !ke[0] && ke != 2*b);
        sp_e = edge_now && ke[0];
      end
      if (cs_n_o !== cs_e) m_cs++;
      if (t <= td && sclk_o !== sc_e) m_sc++;
      if (launch_o !== ln_e) m_ln++;
      if (sample_o !== sp_e) m_sp++;
      if (done_o !== (t == td)) m_dn++;
      if (err_o !== 1'b0) m_er++;
      if (launch_o && sample_o) both++;
      if (t == 2) begin
        ratio_i = DIV_W'(2); cpol_i = ~pol; cpha_i = ~pha;
        bits_i = CNT_W'(5); setup_i = TW'(7); hold_i = TW'(7);
      end
      if (t == 3) start_i = 1'b1;
      if (t == 4) start_i = 1'b0;
      if (t == td) begin
        ratio_i = DIV_W'(ratio); cpol_i = pol; cpha_i = pha;
        bits_i = CNT_W'(b); setup_i = TW'(n); hold_i = TW'(m);
      end
      @(negedge clk);
    end
    check(m_sc == 0, "R2 R3 R4 sclk timing mismatches", m_sc, 0);
    check(m_cs == 0, "R3 R4 cs_n window mismatches", m_cs, 0);
    check(m_dn == 0, "R5 done timing mismatches", m_dn, 0);
    check(m_ln == 0, pha ? "R7 launch mismatches" : "R6 launch mismatches", m_ln, 0);
    check(m_sp == 0, pha ? "R7 sample mismatches" : "R6 sample mismatches", m_sp, 0);
    check(both == 0, "R8 launch and sample overlap", both, 0);
    check(m_er == 0, "R1 err on valid start", m_er, 0);
    check(m_cs + m_sc + m_ln + m_sp + m_dn == 0, "R9 mid-transfer changes altered waveform",
          m_cs + m_sc + m_ln + m_sp + m_dn, 0);
  endtask

  task automatic run_bad(input int ratio, input int b, input string tag);
    int bad_cs, bad_dn;
    bad_cs = 0; bad_dn = 0;
    ratio_i = DIV_W'(ratio); bits_i = CNT_W'(b); setup_i = '0; hold_i = '0;
    cpol_i = 1'b0; cpha_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o === 1'b1, tag, int'(err_o), 1);
    for (int t = 0; t < 12; t++) begin
      if (t == 1) check(err_o === 1'b0, tag, int'(err_o), 0);
      if (cs_n_o !== 1'b1) bad_cs++;
      if (done_o !== 1'b0) bad_dn++;
      @(negedge clk);
    end
    check(bad_cs == 0 && bad_dn == 0, tag, bad_cs + bad_dn, 0);
  endtask

  initial begin
    int rl[4];
    rl = '{1, 2, 4, 6};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(cs_n_o === 1'b1 && sclk_o === 1'b0, "R11 reset cs_n/sclk", {30'd0, cs_n_o, sclk_o}, 2);
    check(!launch_o && !sample_o && !done_o && !err_o, "R11 reset strobes",
          {28'd0, launch_o, sample_o, done_o, err_o}, 0);
    cpol_i = 1'b1;
    @(negedge clk);
    check(sclk_o === 1'b1, "R11 idle sclk follows cpol", int'(sclk_o), 1);
    cpol_i = 1'b0;
    @(negedge clk);
    check(sclk_o === 1'b0, "R11 idle sclk follows cpol low", int'(sclk_o), 0);

    run_bad(0, 3, "R1 ratio 0 refused");
    run_bad(3, 3, "R1 odd ratio refused");
    run_bad(511, 3, "R1 ratio 511 refused");
    run_bad(512, 3, "R1 ratio above 510 refused");
    run_bad(4, 0, "R10 zero bit count refused");
    run_xfer(510, 1'b0, 1'b1, 1, 0, 0);

    foreach (rl[i]) begin
      for (int pol = 0; pol < 2; pol++)
        for (int pha = 0; pha < 2; pha++)
          for (int b = 1; b <= 3; b++)
            for (int n = 0; n <= 2; n++)
              for (int m = 0; m <= 2; m += 2)
                run_xfer(rl[i], pol[0], pha[0], b, n, m);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule